// File: doc/BRIEF.md
# Two-Wire Serial Debug Register Slave

This block is the target side of a serial debug port. An external master drives a clock line and shares a bidirectional data line with the block. Every command opens with a start condition, which is the data line falling while the clock line is high. An address frame follows, and then one or more data frames. Each frame is nine bit times long, and its last bit is a separator driven by the master. A low separator means the command goes on. A high separator ends the command. While the separator stays low and no new start arrives, the block repeats the last read or write on the next byte and steps the register address by one. A multi-byte register can therefore be read or written with a single command.

The read space and the write space are separate even where they share an address. Reads return fixed identification bytes, a revision byte and a read-back window of the match registers. Writes load the match registers, which a breakpoint unit outside this block would compare. Every completed write byte also appears as a one-cycle strobe, with its address and data, for other debug logic. The bus-release output tells the system arbiter whether the port may give up the bus. It is low while a command is active. There is no back-pressure on the strobe: the serial side cannot stall, so a consumer must take the strobe in the cycle it appears.

Top module: `sdbg_slave`

## Requirements
- R1: A fall of the data line while the clock line is high is a start. It restarts framing at bit 0 of an address frame from any state and discards any partial frame. The falling clock edge that directly follows a start does not advance the bit count.
- R2: Bits are sampled on the rising edge of the serial clock, and the block advances its bit position on the falling edge. The address frame carries 7 address bits, most significant first, then one direction bit, then the separator.
- R3: A direction bit of 0 makes the command a write and a value of 1 makes it a read.
- R4: A data frame holds 8 data bits, most significant first, then the separator. Each completed write byte raises `wr_valid_o` for exactly one system cycle, with that byte's address and data.
- R5: After a low separator with no new start, the same operation repeats on the next byte. The address rises by one per data byte and wraps from 0x7F to 0x00.
- R6: A high separator ends the command. Until the next start, clock edges cause no strobe and no drive of the data line.
- R7: `bus_release_o` is 1 after reset and falls to 0 on a start. At each separator it takes the sampled separator value.
- R8: The block drives the data line only during the 8 data bits of read frames. It presents the byte most significant bit first, and each bit stays stable through the high phase of the clock.
- R9: Reads of 0x00, 0x01 and 0x02 return the identification low byte, the identification high byte and the revision byte. Reads of 0x10, 0x11 and 0x12 return match bytes 0, 1 and 2. Reads of any other address return 0x00. Writes to 0x00, 0x01 and 0x02 load match bytes 0, 1 and 2. Writes to any other address change no register, though they still strobe. All match bytes reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_clk_i | input | 1 | Serial clock from the master (asynchronous) |
| dbg_dat_i | input | 1 | Level seen on the shared data line |
| dbg_dat_o | output | 1 | Value the block puts on the data line |
| dbg_dat_oe | output | 1 | Drive enable for the data line |
| bus_release_o | output | 1 | 1 when the port may give up the system bus |
| wr_valid_o | output | 1 | One-cycle strobe per completed write byte |
| wr_addr_o | output | 7 | Register address of the strobed byte |
| wr_data_o | output | 8 | Data of the strobed byte |
| match_value_o | output | 24 | Match bytes, byte 0 in the low bits |

## Verification
Both serial pins pass through two synchronizer flops. The registered edge action therefore becomes visible on the third system clock after a pin changes: a strobe, a new drive value or a bus-release update all arrive then. The bench holds every serial level for five system clocks. It samples read bits at the end of the clock-high phase, when the value driven after the previous falling edge has long settled. It catches the one-cycle write strobe with a monitor that runs on the falling system clock edge. Bus-release, match bytes and strobe counts are checked only once a separator's falling edge has been followed by a full hold time.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/sdbg_sync.sv
module sdbg_sync #(
  parameter int             W      = 2,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/sdbg_regs.sv
module sdbg_regs #(
  parameter int              AW       = 7,
  parameter int              DW       = 8,
  parameter int              NM       = 3,
  parameter int              MIRROR   = 16,
  parameter logic [2*DW-1:0] ID_WORD  = 16'hA55C,
  parameter logic [DW-1:0]   REV_BYTE = 8'h21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NM*DW-1:0] match_value
);

  logic [DW-1:0] mreg [NM];

  for (genvar i = 0; i < NM; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mreg[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))       mreg[i] <= wr_data;
    end
    assign match_value[i*DW +: DW] = mreg[i];

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != AW'(i)) |=> $stable(mreg[i])); // R9
    AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(i)) |=> mreg[i] == $past(wr_data)); // R9
  end

  // Read side: fixed identity bytes low, mirror window of the match bytes.
  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(0))      rd_data = ID_WORD[DW-1:0];
    else if (rd_addr == AW'(1)) rd_data = ID_WORD[2*DW-1:DW];
    else if (rd_addr == AW'(2)) rd_data = REV_BYTE;
    for (int i = 0; i < NM; i++) begin
      if (rd_addr == AW'(MIRROR + i)) rd_data = mreg[i];
    end
  end

endmodule

// File: rtl/sdbg_frame.sv
module sdbg_frame
  import sdbg_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_clk,
  input  logic          s_dat,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          drv_oe,
  output logic          drv_bit,
  output logic          bus_release
);

  localparam int          CW   = $clog2(DW + 1);
  localparam logic [CW-1:0] SEP  = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          s_clk_d, s_dat_d;
  logic [AW-1:0] shift;
  logic [AW-1:0] addr;
  logic          rw;
  logic [DW-1:0] rd_shift;

  logic rise, fall, start_det;
  assign rise      = s_clk & ~s_clk_d;
  assign fall      = ~s_clk & s_clk_d;
  assign start_det = s_clk & s_clk_d & s_dat_d & ~s_dat;

  assign rd_addr = (phase == PH_ADDR) ? addr : addr + AW'(1);
  assign drv_oe  = (phase == PH_DATA) && rw && !pend && (cnt < SEP);
  assign drv_bit = rd_shift[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      pend        <= 1'b0;
      s_clk_d     <= 1'b0;
      s_dat_d     <= 1'b1;
      shift       <= '0;
      addr        <= '0;
      rw          <= 1'b0;
      rd_shift    <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      bus_release <= 1'b1;
    end else begin
      s_clk_d  <= s_clk;
      s_dat_d  <= s_dat;
      wr_valid <= 1'b0;
      if (start_det) begin
        phase       <= PH_ADDR;
        cnt         <= '0;
        pend        <= 1'b1;
        bus_release <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (rise) begin
          if (cnt == SEP) begin
            bus_release <= s_dat;
          end else begin
            shift <= {shift[AW-2:0], s_dat};
            if (cnt == LAST) begin
              if (phase == PH_ADDR) begin
                addr <= shift;
                rw   <= s_dat;
              end else if (!rw) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= {shift, s_dat};
              end
            end
          end
        end else if (fall) begin
          if (pend) begin
            pend <= 1'b0;
          end else if (cnt == SEP) begin
            cnt <= '0;
            if (bus_release) begin
              phase <= PH_IDLE;
            end else begin
              if (phase == PH_DATA) addr <= addr + AW'(1);
              phase    <= PH_DATA;
              rd_shift <= rd_data;
            end
          end else begin
            cnt      <= cnt + CW'(1);
            rd_shift <= {rd_shift[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (cnt == '0 && phase == PH_ADDR && pend)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4
  AST_STROBE_AT_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (cnt == LAST && phase == PH_DATA && !rw)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && fall && !pend && !start_det && cnt == SEP && !bus_release)
      |=> addr == $past(addr) + AW'(1)); // R5
  AST_RELEASE_ON_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_release) |-> $past(cnt) == SEP); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !wr_valid); // R6

endmodule

// File: rtl/sdbg_slave.sv
module sdbg_slave #(
  parameter int               DATA_W      = 8,
  parameter int               MATCH_BYTES = 3,
  parameter int               MIRROR_BASE = 16,
  parameter logic [2*DATA_W-1:0] ID_WORD  = 16'hA55C,
  parameter logic [DATA_W-1:0]   REV_BYTE = 8'h21,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dbg_clk_i,
  input  logic                          dbg_dat_i,
  output logic                          dbg_dat_o,
  output logic                          dbg_dat_oe,
  output logic                          bus_release_o,
  output logic                          wr_valid_o,
  output logic [DATA_W-2:0]             wr_addr_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic [MATCH_BYTES*DATA_W-1:0] match_value_o
);

  localparam int ADDR_W = DATA_W - 1;

  logic [1:0]        sync_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  sdbg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST(2'b10)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dbg_dat_i, dbg_clk_i}),
    .q     (sync_q)
  );

  sdbg_frame #(.DW(DATA_W), .AW(ADDR_W)) frame_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_clk       (sync_q[0]),
    .s_dat       (sync_q[1]),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_valid    (wr_valid_o),
    .wr_addr     (wr_addr_o),
    .wr_data     (wr_data_o),
    .drv_oe      (dbg_dat_oe),
    .drv_bit     (dbg_dat_o),
    .bus_release (bus_release_o)
  );

  sdbg_regs #(
    .AW(ADDR_W), .DW(DATA_W), .NM(MATCH_BYTES), .MIRROR(MIRROR_BASE),
    .ID_WORD(ID_WORD), .REV_BYTE(REV_BYTE)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_valid_o),
    .wr_addr     (wr_addr_o),
    .wr_data     (wr_data_o),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .match_value (match_value_o)
  );

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !dbg_dat_oe); // R8

endmodule

// File: tb/sdbg_slave_tb_top.sv
module sdbg_slave_tb_top;

  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sda_m = 1'b1;
  logic line;
  logic dat_o, dat_oe, brel, wrv;
  logic [6:0]  wra;
  logic [7:0]  wrd;
  logic [23:0] mval;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int          st_n = 0;
  logic [6:0]  st_a [0:511];
  logic [7:0]  st_d [0:511];
  logic [7:0]  m [0:2];

  always #5 clk = ~clk;

  assign line = dat_oe ? dat_o : sda_m;

  sdbg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_clk_i(sclk), .dbg_dat_i(line),
    .dbg_dat_o(dat_o), .dbg_dat_oe(dat_oe), .bus_release_o(brel),
    .wr_valid_o(wrv), .wr_addr_o(wra), .wr_data_o(wrd), .match_value_o(mval)
  );

  always @(negedge clk) begin
    if (wrv && st_n < 512) begin
      st_a[st_n] = wra;
      st_d[st_n] = wrd;
      st_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 0) return 8'h5C;
    if (a == 1) return 8'hA5;
    if (a == 2) return 8'h21;
    if (a >= 16 && a <= 18) return m[a-16];
    return 8'h00;
  endfunction

  function automatic logic [7:0] wval(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic hold();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic got, output logic got_oe);
    sda_m = b;
    hold();
    sclk = 1'b1;
    hold();
    got = line;
    got_oe = dat_oe;
    sclk = 1'b0;
    hold();
  endtask

  task automatic start_cond();
    sda_m = 1'b1; hold();
    sclk = 1'b1;  hold();
    sda_m = 1'b0; hold();
    sclk = 1'b0;  hold();
  endtask

  task automatic send_cmd(input logic [6:0] a, input logic rd);
    logic g, go;
    for (int i = 6; i >= 0; i--) bit_io(a[i], g, go);
    bit_io(rd, g, go);
    bit_io(1'b0, g, go);
  endtask

  task automatic write_byte(input logic [7:0] d, input logic sep, output logic any_oe);
    logic g, go;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(d[i], g, go);
      any_oe |= go;
    end
    bit_io(sep, g, go);
    any_oe |= go;
  endtask

  task automatic read_byte(input logic sep, output logic [7:0] d, output logic all_oe,
                           output logic sep_oe);
    logic g, go;
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, g, go);
      d[i] = g;
      all_oe &= go;
    end
    bit_io(sep, g, sep_oe);
  endtask

  initial begin
    logic [7:0] d;
    logic ao, so, anyo;
    int n0;
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R7 reset release", 32'(brel), 1);
    chk("R8 reset no drive", 32'(dat_oe), 0);
    chk("R4 reset no strobe", 32'(wrv), 0);
    chk("R9 reset match", 32'(mval), 0);

    // Read sweep over the whole address space, single byte per command
    for (int a = 0; a < 128; a++) begin
      start_cond();
      if (a == 0) chk("R7 low after start", 32'(brel), 0);
      send_cmd(7'(a), 1'b1);
      read_byte(1'b1, d, ao, so);
      chk($sformatf("R9 read addr %0h", a), 32'(d), 32'(exp_rd(a)));
      if (a % 16 == 0) begin
        chk("R8 drive on data bits", 32'(ao), 1);
        chk("R8 no drive on separator", 32'(so), 0);
        chk("R7 high after high separator", 32'(brel), 1);
      end
    end

    // Write sweep: one strobe per byte, only 0..2 load match bytes
    for (int a = 0; a < 128; a++) begin
      n0 = st_n;
      start_cond();
      send_cmd(7'(a), 1'b0);
      if (a == 5) chk("R7 low during command", 32'(brel), 0);
      write_byte(wval(a), 1'b1, anyo);
      chk($sformatf("R4 strobe count addr %0h", a), 32'(st_n - n0), 1);
      chk($sformatf("R3 strobe addr %0h", a), 32'(st_a[n0]), 32'(a));
      chk($sformatf("R2 strobe data addr %0h", a), 32'(st_d[n0]), 32'(wval(a)));
      if (a < 3) m[a] = wval(a);
      if (a % 32 == 0) chk("R8 no drive in write", 32'(anyo), 0);
    end
    chk("R9 match after sweep", 32'(mval), 32'({m[2], m[1], m[0]}));

    // Repeated read from 0: identity and revision, then the mirror window
    start_cond();
    send_cmd(7'h00, 1'b1);
    for (int k = 0; k < 3; k++) begin
      read_byte(k == 2, d, ao, so);
      chk($sformatf("R5 repeat read %0d", k), 32'(d), 32'(exp_rd(k)));
      if (k == 0) chk("R7 low separator keeps release low", 32'(brel), 0);
    end
    start_cond();
    send_cmd(7'h10, 1'b1);
    for (int k = 0; k < 3; k++) begin
      read_byte(k == 2, d, ao, so);
      chk($sformatf("R9 mirror read %0d", k), 32'(d), 32'(m[k]));
    end

    // Repeated write crossing the top of the address space
    n0 = st_n;
    start_cond();
    send_cmd(7'h7E, 1'b0);
    write_byte(8'h11, 1'b0, anyo);
    write_byte(8'h22, 1'b0, anyo);
    write_byte(8'h33, 1'b1, anyo);
    m[0] = 8'h33;
    chk("R5 repeat write count", 32'(st_n - n0), 3);
    chk("R5 addr step", 32'(st_a[n0+1]), 32'h7F);
    chk("R5 addr wrap", 32'(st_a[n0+2]), 32'h00);
    chk("R5 wrap data", 32'(st_d[n0+2]), 32'h33);
    chk("R9 wrap loads match 0", 32'(mval), 32'({m[2], m[1], m[0]}));

    // After a high separator clock edges do nothing
    n0 = st_n;
    anyo = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic g, go;
      for (int i = 0; i < 9; i++) begin
        bit_io(1'b0, g, go);
        anyo |= go;
      end
    end
    chk("R6 no strobe while idle", 32'(st_n - n0), 0);
    chk("R6 no drive while idle", 32'(anyo), 0);
    chk("R6 release stays high", 32'(brel), 1);

    // Start inside a partial write frame discards it
    n0 = st_n;
    start_cond();
    send_cmd(7'h01, 1'b0);
    begin
      logic g, go;
      for (int i = 0; i < 5; i++) bit_io(1'b1, g, go);
    end
    start_cond();
    chk("R1 release low after restart", 32'(brel), 0);
    send_cmd(7'h02, 1'b0);
    write_byte(8'h3C, 1'b1, anyo);
    m[2] = 8'h3C;
    chk("R1 single strobe after restart", 32'(st_n - n0), 1);
    chk("R1 restart addr", 32'(st_a[n0]), 32'h02);
    chk("R1 partial frame discarded", 32'(mval), 32'({m[2], m[1], m[0]}));

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule